// File: doc/BRIEF.md
# Priority-Ordered Interrupt Polling Sequencer

This block sits on the processor side of a single interrupt request wire that several devices drive together. When the wire is seen asserted, the sequencer works out which device raised it. It places binary device addresses on a narrow polling bus, one address per cycle, starting with the most urgent device. The addressed device answers on a shared response wire in the same cycle.

The first address that answers ends the scan. That index is then presented to the processor, and the sequencer waits for an acknowledge before it listens to the request wire again. A scan that reaches the last device with no answer is reported as spurious, and the block goes back to waiting. Address 0 carries the highest priority, so when several devices answer, the one with the lowest address wins.

Top module: `irq_poll_seq`

## Requirements
- R1: While `rst` is high at a rising clock edge, the block goes idle. After that edge `poll_addr` is 0 and `poll_active`, `found_vld` and `spurious` are all low.
- R2: When `irq_req` is high during an idle cycle, the scan starts at address 0 two clock edges later. So a device at address k is reported with `found_vld` k+3 edges after `irq_req` was first driven high.
- R3: While `poll_active` is high, `poll_addr` rises by exactly one per cycle and never goes past NUM_DEV-1.
- R4: The scan stops at the first address whose cycle has `poll_rsp` high. If several devices answer, `found_idx` is the lowest answering address.
- R5: `found_vld` stays high with a constant `found_idx` until a cycle in which `found_ack` is high, and drops after that edge. `poll_addr` is 0 whenever `poll_active` is low.
- R6: If no device answers through address NUM_DEV-1, `spurious` is high for exactly one cycle directly after that scan cycle. The block is then idle and `found_vld` stays low.
- R7: A new scan starts only after the block has spent at least one cycle idle after an acknowledge or a spurious result, with `irq_req` sampled high in an idle cycle. If `irq_req` stays high across the acknowledge, the next scan starts with the second edge after the acknowledge edge.
- R8: `poll_rsp` has no effect outside a scan, and `irq_req` has no effect while a scan or a held result is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 1 | Shared interrupt request wire from all devices |
| poll_rsp | input | 1 | Shared answer from the device addressed this cycle |
| found_ack | input | 1 | Processor acknowledge of the reported index |
| poll_addr | output | ADDR_W | Binary address of the device polled this cycle |
| poll_active | output | 1 | High during scan cycles |
| found_vld | output | 1 | A requesting device has been found |
| found_idx | output | ADDR_W | Index of the found device |
| spurious | output | 1 | One-cycle pulse: a scan ended with no answer |

## Verification
The hardest situation to reach from the ports is re-arming while the request wire is still held high across an acknowledge. A careless design restarts on the acknowledge edge itself or never restarts. The bench holds `irq_req` high through a found result and its acknowledge, then checks cycle by cycle that the block stays idle for two observed cycles and starts the next scan at address 0 right after. The bench also asserts reset in the middle of a scan, and drives `poll_rsp` high whenever no scan is running, so that stray answers in idle and hold cycles are exercised on every vector.

// File: rtl/irq_poll_pkg.sv
package irq_poll_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_HOLD = 2'd2
    } poll_state_e;

endpackage

// File: rtl/irq_req_sampler.sv
module irq_req_sampler (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic irq_req,
    output logic req_seen
);
    typedef struct packed {
        logic seen;
    } smp_t;

    smp_t smp_d, smp_q;

    always_comb begin
        smp_d      = smp_q;
        // only a sample taken while armed counts; disarmed cycles clear it
        smp_d.seen = arm & irq_req;
    end

    always_ff @(posedge clk) begin
        if (rst) smp_q <= '0;
        else     smp_q <= smp_d;
    end

    assign req_seen = smp_q.seen;

    // R7: a request sample only survives from a cycle that was armed
    p_seen_needs_arm_r7: assert property (@(posedge clk) disable iff (rst)
        req_seen |-> $past(arm));
endmodule

// File: rtl/poll_addr_ctr.sv
module poll_addr_ctr #(
    parameter int NUM_DEV = 8,
    parameter int ADDR_W  = $clog2(NUM_DEV)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_DEV - 1);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
    } ctr_t;

    ctr_t ctr_d, ctr_q;

    always_comb begin
        ctr_d = ctr_q;
        if (clr) begin
            ctr_d.addr = '0;
        end else if (step && (ctr_q.addr != LAST_ADDR)) begin
            ctr_d.addr = ctr_q.addr + ADDR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ctr_q <= '0;
        else     ctr_q <= ctr_d;
    end

    assign addr = ctr_q.addr;
    assign last = (ctr_q.addr == LAST_ADDR);

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        addr <= LAST_ADDR);
endmodule

// File: rtl/irq_poll_seq.sv
module irq_poll_seq #(
    parameter int NUM_DEV = 8,
    parameter int ADDR_W  = $clog2(NUM_DEV)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              irq_req,
    input  logic              poll_rsp,
    input  logic              found_ack,
    output logic [ADDR_W-1:0] poll_addr,
    output logic              poll_active,
    output logic              found_vld,
    output logic [ADDR_W-1:0] found_idx,
    output logic              spurious
);
    import irq_poll_pkg::*;

    typedef struct packed {
        poll_state_e       state;
        logic [ADDR_W-1:0] idx;
        logic              spur;
    } seq_t;

    seq_t seq_d, seq_q;

    logic              req_seen;
    logic              arm;
    logic              ctr_clr;
    logic              ctr_step;
    logic [ADDR_W-1:0] cur_addr;
    logic              cur_last;

    assign arm = (seq_q.state == ST_IDLE);

    irq_req_sampler u_sampler (
        .clk      (clk),
        .rst      (rst),
        .arm      (arm),
        .irq_req  (irq_req),
        .req_seen (req_seen)
    );

    poll_addr_ctr #(
        .NUM_DEV (NUM_DEV),
        .ADDR_W  (ADDR_W)
    ) u_ctr (
        .clk  (clk),
        .rst  (rst),
        .clr  (ctr_clr),
        .step (ctr_step),
        .addr (cur_addr),
        .last (cur_last)
    );

    always_comb begin
        seq_d      = seq_q;
        seq_d.spur = 1'b0;
        ctr_clr    = 1'b0;
        ctr_step   = 1'b0;
        unique case (seq_q.state)
            ST_IDLE: begin
                ctr_clr = 1'b1;
                if (req_seen) seq_d.state = ST_SCAN;
            end
            ST_SCAN: begin
                if (poll_rsp) begin
                    seq_d.idx   = cur_addr;
                    seq_d.state = ST_HOLD;
                    ctr_clr     = 1'b1;
                end else if (cur_last) begin
                    seq_d.spur  = 1'b1;
                    seq_d.state = ST_IDLE;
                    ctr_clr     = 1'b1;
                end else begin
                    ctr_step = 1'b1;
                end
            end
            ST_HOLD: begin
                ctr_clr = 1'b1;
                if (found_ack) seq_d.state = ST_IDLE;
            end
            default: begin
                seq_d.state = ST_IDLE;
                ctr_clr     = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q.state <= ST_IDLE;
            seq_q.idx   <= '0;
            seq_q.spur  <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign poll_addr   = cur_addr;
    assign poll_active = (seq_q.state == ST_SCAN);
    assign found_vld   = (seq_q.state == ST_HOLD);
    assign found_idx   = seq_q.idx;
    assign spurious    = seq_q.spur;

    // R1: at most one of the three status outputs at a time
    p_excl_status_r1: assert property (@(posedge clk) disable iff (rst)
        $onehot0({poll_active, found_vld, spurious}));

    p_first_addr_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(poll_active) |-> (poll_addr == '0));

    p_addr_step_r3: assert property (@(posedge clk) disable iff (rst)
        (poll_active && $past(poll_active)) |-> (poll_addr == $past(poll_addr) + ADDR_W'(1)));

    p_stop_on_rsp_r4: assert property (@(posedge clk) disable iff (rst)
        (poll_active && poll_rsp) |=> (found_vld && found_idx == $past(poll_addr)));

    p_hold_stable_r5: assert property (@(posedge clk) disable iff (rst)
        (found_vld && !found_ack) |=> (found_vld && $stable(found_idx)));

    p_addr_zero_idle_r5: assert property (@(posedge clk) disable iff (rst)
        !poll_active |-> (poll_addr == '0));

    p_spur_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        spurious |=> !spurious);

    p_rearm_gap_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(found_vld) |=> !poll_active);
endmodule

// File: tb/irq_poll_seq_tb_top.sv
module irq_poll_seq_tb_top;
    localparam int NDEV  = 8;
    localparam int AW    = $clog2(NDEV);
    localparam int NVEC  = 7;

    // per vector: device answer mask; expected {spurious, index}
    localparam logic [NDEV-1:0] MASKS [NVEC] = '{
        8'b0000_0001, 8'b1000_0000, 8'b0010_1000, 8'b1111_1110,
        8'b0000_0000, 8'b0100_0000, 8'b1111_1111 };
    localparam logic [AW:0] EXPS [NVEC] = '{
        4'b0_000, 4'b0_111, 4'b0_011, 4'b0_001,
        4'b1_000, 4'b0_110, 4'b0_000 };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          irq_req = 1'b0;
    logic          poll_rsp = 1'b0;
    logic          found_ack = 1'b0;
    logic [AW-1:0] poll_addr;
    logic          poll_active;
    logic          found_vld;
    logic [AW-1:0] found_idx;
    logic          spurious;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    always #2.5 clk = ~clk;

    irq_poll_seq #(.NUM_DEV(NDEV)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .irq_req     (irq_req),
        .poll_rsp    (poll_rsp),
        .found_ack   (found_ack),
        .poll_addr   (poll_addr),
        .poll_active (poll_active),
        .found_vld   (found_vld),
        .found_idx   (found_idx),
        .spurious    (spurious)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: run hung, act=%0d exp<=100000 cycles", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_fail);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: act=%0d exp=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // device model: answer the addressed device; outside a scan drive a stray 1 (R8)
    task automatic drive_rsp(input logic [NDEV-1:0] mask);
        poll_rsp = poll_active ? mask[poll_addr] : 1'b1;
    endtask

    task automatic run_vec(input logic [NDEV-1:0] mask, input logic [AW:0] expv);
        int seen = 0;
        int exp_addr = 0;
        @(negedge clk);
        irq_req = 1'b1;
        drive_rsp(mask);
        for (int c = 1; c <= 40; c++) begin
            @(negedge clk);
            if (poll_active) begin
                if (exp_addr == 0) check(c == 2, "R2 scan start cycle", c, 2);
                check(poll_addr == AW'(exp_addr), "R3 address order", poll_addr, exp_addr);
                exp_addr++;
            end
            drive_rsp(mask);
            if (found_vld || spurious) begin
                seen = c;
                break;
            end
        end
        if (expv[AW]) begin
            check(spurious && !found_vld, "R6 spurious raised", spurious, 1);
            check(seen == NDEV + 2, "R6 spurious timing", seen, NDEV + 2);
            irq_req = 1'b0;
            @(negedge clk);
            drive_rsp(mask);
            check(!spurious && !poll_active && !found_vld, "R6 one-cycle pulse, idle",
                  {spurious, poll_active, found_vld}, 0);
        end else begin
            check(found_vld, "R4 found", found_vld, 1);
            check(found_idx == expv[AW-1:0], "R4 lowest answering index", found_idx, expv[AW-1:0]);
            check(seen == int'(expv[AW-1:0]) + 3, "R2 found latency", seen, int'(expv[AW-1:0]) + 3);
            for (int h = 0; h < 3; h++) begin
                @(negedge clk);
                drive_rsp(mask);
                check(found_vld && found_idx == expv[AW-1:0] && !poll_active,
                      "R5 R8 held result", found_idx, expv[AW-1:0]);
                check(poll_addr == '0, "R5 addr zero when not scanning", poll_addr, 0);
            end
            found_ack = 1'b1;
            irq_req   = 1'b0;
            @(negedge clk);
            found_ack = 1'b0;
            drive_rsp(mask);
            check(!found_vld && !poll_active, "R5 release on ack", found_vld, 0);
        end
        for (int i = 0; i < 2; i++) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(poll_addr == '0 && !poll_active && !found_vld && !spurious,
              "R1 reset state", {poll_addr, poll_active, found_vld, spurious}, 0);
        rst = 1'b0;

        // R8: stray answers with no request do nothing
        poll_rsp = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check(!poll_active && !found_vld && !spurious, "R8 idle ignores poll_rsp",
                  {poll_active, found_vld, spurious}, 0);
        end

        for (int v = 0; v < NVEC; v++) run_vec(MASKS[v], EXPS[v]);

        // R7: request held high across the acknowledge
        @(negedge clk);
        irq_req = 1'b1;
        drive_rsp(8'b0000_0100);
        for (int c = 0; c < 20 && !found_vld; c++) begin
            @(negedge clk);
            drive_rsp(8'b0000_0100);
        end
        check(found_vld && found_idx == AW'(2), "R7 setup found", found_idx, 2);
        found_ack = 1'b1;
        @(negedge clk);
        found_ack = 1'b0;
        drive_rsp(8'b0000_0001);
        check(!poll_active && !found_vld, "R7 idle after ack edge", poll_active, 0);
        @(negedge clk);
        drive_rsp(8'b0000_0001);
        check(!poll_active, "R7 second idle cycle", poll_active, 0);
        @(negedge clk);
        check(poll_active && poll_addr == '0, "R7 rescan at address 0", poll_active, 1);
        drive_rsp(8'b0000_0001);
        irq_req = 1'b0;
        @(negedge clk);
        check(found_vld && found_idx == '0, "R7 rescan result", found_idx, 0);
        found_ack = 1'b1;
        @(negedge clk);
        found_ack = 1'b0;

        // R1: reset in the middle of a scan
        irq_req  = 1'b1;
        poll_rsp = 1'b0;
        repeat (4) @(negedge clk);
        check(poll_active, "R1 scan running before reset", poll_active, 1);
        rst = 1'b1;
        @(negedge clk);
        check(poll_addr == '0 && !poll_active && !found_vld && !spurious,
              "R1 reset mid-scan", {poll_addr, poll_active, found_vld, spurious}, 0);
        rst = 1'b0;
        irq_req = 1'b0;
        repeat (3) @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule